// File: doc/BRIEF.md
# Serial TDM Output Frame Builder

This block is the transmit half of a controller-side serial audio link. It runs directly on the 12.288 MHz bit clock delivered by the codec and produces two outputs: a frame synchronisation strobe and one serial data line. Every 256 bit clocks it sends one frame, which gives a 48 kHz frame rate. A frame opens with a 16-bit tag word, and twelve 20-bit slots follow it. The first two slots carry a register command (address/direction and write data). The other ten slots carry audio or modem sample words.

The surrounding controller supplies the sample words with one valid flag per slot, an optional register command, a target codec ID and a sample-width select. On the first bit clock of each frame the block takes a copy of all of these inputs. From that copy it builds the tag word, following separate rules for primary reads, primary writes and secondary-codec accesses. It then shifts the whole frame out MSB first. Any slot not marked valid goes out as zeros, and the trailing bits of samples narrower than 20 bits are also sent as zeros.

Top module: `acl_frame_tx`

## Requirements
- R1: A new frame starts every 256 bit clocks. The sync output rises once per frame and frames follow each other with no gap.
- R2: Sync is high for exactly 16 bit clocks, the tag phase. It goes high on the same rising edge that drives the first tag bit (tag bit 15) onto the data line.
- R3: Tag bit 15 (frame valid) is 1 exactly when a command is present or at least one of the ten data slots is valid.
- R4: Tag bits 12 down to 3 flag data slots 3 to 12, with `data_valid_i[0]` (slot 3) driving bit 12 and `data_valid_i[9]` (slot 12) driving bit 3. Tag bit 2 is always 0.
- R5: A primary read (codec ID 00, command with read = 1) sets tag bits 15 and 14, clears bit 13 and sends 00 in tag bits 1:0. Slot 1 carries 1 in bit 19, the 7-bit register index in bits 18:12 and zeros below. Slot 2 is all zeros.
- R6: A primary write (codec ID 00, command with read = 0) sets tag bits 15, 14 and 13. Slot 1 carries 0 in bit 19 and the index in bits 18:12. Slot 2 carries the 16-bit write data in bits 19:4, with bits 3:0 zero.
- R7: A command with a nonzero codec ID (01, 10, 11) sets tag bit 15, clears tag bits 14 and 13 and places the ID in tag bits 1:0. Slots 1 and 2 still carry the command as in R5 and R6.
- R8: A slot with no valid content is sent as 20 zeros. This covers data slots whose valid flag is 0, and slots 1 and 2 when no command is present (slot 2 also on reads). With nothing valid, the whole frame is zero.
- R9: The width select trims every data slot. Code 00 sends 16 bits and zeros bits 3:0. Code 01 sends 18 bits and zeros bits 1:0. Codes 10 and 11 send all 20 bits.
- R10: Bits are sent MSB first: the tag from bit 15, then slots 1 to 12 in order, each from bit 19 down to bit 0. Data slot n+3 is taken from `data_i[n*20 +: 20]`.
- R11: Inputs are taken only on the first bit clock of a frame. Input changes during the rest of the frame do not alter that frame, and they appear in the next frame.
- R12: While reset is low, sync and data are held low. The first frame starts on the first rising edge with reset high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 12.288 MHz; outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | A register command is to be sent in the next frame |
| cmd_read_i | input | 1 | 1 = read command, 0 = write command |
| cmd_index_i | input | 7 | Register index placed in slot 1 bits 18:12 |
| cmd_wdata_i | input | 16 | Write data placed in slot 2 bits 19:4 |
| codec_id_i | input | 2 | Target codec; 00 = primary, nonzero = secondary |
| width_sel_i | input | 2 | Sample width for data slots: 00 = 16, 01 = 18, 10/11 = 20 bits |
| data_valid_i | input | 10 | Valid flag per data slot, bit 0 = slot 3 |
| data_i | input | 200 | Ten 20-bit sample words, bits [n*20 +: 20] = slot n+3 |
| sync_o | output | 1 | Frame sync, high during the 16-bit tag phase |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
Faults in this block show up on the data line within the frame they affect. A wrong bit counter moves the sync edge or the frame length, and the period check catches this on the second frame. A bad tag or slot assembly, or a wrong width mask, corrupts particular bit positions of the 256-bit frame that the bench captures. Because the whole frame is compared against a value computed in the bench, every bit position is checked in the frame where it first goes wrong. A latching fault, where inputs leak into a frame already in progress, shows up only when inputs change in the middle of a frame. The bench therefore changes them at bit 120 and expects the old values to finish the frame and the new values to appear in the next frame.

// File: rtl/acl_tx_pkg.sv
// Shared constants, types and helpers for the serial TDM frame builder.
// Assumes a fixed 16-bit tag followed by two command slots and ten data slots.
package acl_tx_pkg;
    localparam int SLOT_W     = 20;
    localparam int TAG_W      = 16;
    localparam int CMD_SLOTS  = 2;
    localparam int DATA_SLOTS = 10;
    localparam int ALL_SLOTS  = CMD_SLOTS + DATA_SLOTS;
    localparam int FRAME_W    = TAG_W + ALL_SLOTS * SLOT_W;
    localparam int IDX_W      = 7;
    localparam int REGD_W     = 16;
    localparam int ID_W       = 2;
    localparam int CNT_W      = $clog2(FRAME_W);
    localparam int IDX_PAD    = SLOT_W - 1 - IDX_W;
    localparam int REGD_PAD   = SLOT_W - REGD_W;
    localparam int DATA_BASE  = FRAME_W - TAG_W - CMD_SLOTS * SLOT_W;

    typedef enum logic [1:0] {
        WID_16  = 2'b00,
        WID_18  = 2'b01,
        WID_20  = 2'b10,
        WID_20B = 2'b11
    } width_e;

    typedef struct packed {
        logic              valid;
        logic              read;
        logic [IDX_W-1:0]  index;
        logic [REGD_W-1:0] wdata;
    } cmd_t;

    // Mask keeping the upper sample bits for the chosen width.
    function automatic logic [SLOT_W-1:0] width_mask(width_e w);
        logic [SLOT_W-1:0] ones;
        ones = '1;
        case (w)
            WID_16:  return ones << (SLOT_W - 16);
            WID_18:  return ones << (SLOT_W - 18);
            default: return ones;
        endcase
    endfunction
endpackage

// File: rtl/acl_cmd_tag_enc.sv
// Tag and command-slot encoder.
// Builds the 16-bit tag word plus slot 1 (address/direction) and slot 2
// (write data) from the command, the codec ID and the data-slot valid flags.
// Assumes codec ID 00 addresses the primary codec; any other ID is secondary,
// which hides the command-slot valid bits and uses the ID field instead.
module acl_cmd_tag_enc
    import acl_tx_pkg::*;
(
    input  cmd_t                  cmd_i,
    input  logic [ID_W-1:0]       codec_id_i,
    input  logic [DATA_SLOTS-1:0] data_valid_i,
    output logic [TAG_W-1:0]      tag_o,
    output logic [SLOT_W-1:0]     slot1_o,
    output logic [SLOT_W-1:0]     slot2_o
);
    logic secondary;
    logic is_write;

    assign secondary = |codec_id_i;
    assign is_write  = cmd_i.valid & ~cmd_i.read;

    // Tag word: frame valid, command slot flags, data slot flags, codec ID.
    always_comb begin
        tag_o                = '0;
        tag_o[TAG_W-1]       = cmd_i.valid | (|data_valid_i);
        tag_o[TAG_W-2]       = cmd_i.valid & ~secondary;
        tag_o[TAG_W-3]       = is_write & ~secondary;
        for (int i = 0; i < DATA_SLOTS; i++) begin
            tag_o[TAG_W-4-i] = data_valid_i[i];
        end
        tag_o[ID_W-1:0]      = cmd_i.valid ? codec_id_i : '0;
    end

    // Slot 1: direction bit and register index, zero-filled below.
    always_comb begin
        if (cmd_i.valid) slot1_o = {cmd_i.read, cmd_i.index, {IDX_PAD{1'b0}}};
        else             slot1_o = '0;
    end

    // Slot 2: write data left-justified, zero for reads or no command.
    always_comb begin
        if (is_write) slot2_o = {cmd_i.wdata, {REGD_PAD{1'b0}}};
        else          slot2_o = '0;
    end
endmodule

// File: rtl/acl_slot_fmt.sv
// Data-slot formatter.
// For each data slot, passes the sample when its valid flag is set and
// clears the trailing bits beyond the selected sample width; sends zeros
// otherwise. Purely combinational; one identical lane per slot.
module acl_slot_fmt
    import acl_tx_pkg::*;
(
    input  logic [DATA_SLOTS*SLOT_W-1:0] data_i,
    input  logic [DATA_SLOTS-1:0]        valid_i,
    input  width_e                       width_i,
    output logic [DATA_SLOTS*SLOT_W-1:0] slots_o
);
    logic [SLOT_W-1:0] mask;

    assign mask = width_mask(width_i);

    for (genvar g = 0; g < DATA_SLOTS; g++) begin : g_lane
        // One lane: gate by valid, trim to width.
        assign slots_o[g*SLOT_W +: SLOT_W] =
            valid_i[g] ? (data_i[g*SLOT_W +: SLOT_W] & mask) : '0;
    end
endmodule

// File: rtl/acl_frame_shifter.sv
// Frame shifter and sync generator.
// Counts bit positions 0..FRAME_W-1; at position 0 it captures the whole
// assembled frame and emits its MSB, then emits one bit per clock.
// Sync is high while positions 0..TAG_W-1 are on the line.
// Assumes frame_i is stable in the cycle where position 0 is taken.
module acl_frame_shifter
    import acl_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sync_o,
    output logic               sdata_o
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TAG_LEN  = CNT_W'(TAG_W);

    logic [CNT_W-1:0]   pos;
    logic [FRAME_W-1:0] shreg;

    // Bit position counter, wraps at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)               pos <= '0;
        else if (pos == LAST_POS) pos <= '0;
        else                      pos <= pos + CNT_W'(1);
    end

    // Shift register: load a fresh frame at position 0, else shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (pos == 0) shreg <= {frame_i[FRAME_W-2:0], 1'b0};
        else               shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end

    // Serial data output register, MSB of the current frame first.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdata_o <= 1'b0;
        else if (pos == 0) sdata_o <= frame_i[FRAME_W-1];
        else               sdata_o <= shreg[FRAME_W-1];
    end

    // Sync output register, high for the tag positions.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_o <= 1'b0;
        else        sync_o <= (pos < TAG_LEN);
    end
endmodule

// File: rtl/acl_frame_tx.sv
// Top of the serial TDM output frame builder.
// Joins the tag/command encoder and the data-slot formatter into one
// FRAME_W-bit word (tag, slot 1, slot 2, slots 3..12 from MSB down) and
// hands it to the shifter, which captures it at each frame start.
// Assumes clk is the link bit clock and rst_n is synchronous to it.
module acl_frame_tx
    import acl_tx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid_i,
    input  logic                         cmd_read_i,
    input  logic [IDX_W-1:0]             cmd_index_i,
    input  logic [REGD_W-1:0]            cmd_wdata_i,
    input  logic [ID_W-1:0]              codec_id_i,
    input  logic [1:0]                   width_sel_i,
    input  logic [DATA_SLOTS-1:0]        data_valid_i,
    input  logic [DATA_SLOTS*SLOT_W-1:0] data_i,
    output logic                         sync_o,
    output logic                         sdata_o
);
    cmd_t                         cmd;
    logic [TAG_W-1:0]             tag_w;
    logic [SLOT_W-1:0]            slot1_w;
    logic [SLOT_W-1:0]            slot2_w;
    logic [DATA_SLOTS*SLOT_W-1:0] fmt_w;
    logic [FRAME_W-1:0]           frame_w;

    assign cmd = '{valid: cmd_valid_i, read: cmd_read_i,
                   index: cmd_index_i, wdata: cmd_wdata_i};

    acl_cmd_tag_enc u_tag (
        .cmd_i        (cmd),
        .codec_id_i   (codec_id_i),
        .data_valid_i (data_valid_i),
        .tag_o        (tag_w),
        .slot1_o      (slot1_w),
        .slot2_o      (slot2_w)
    );

    acl_slot_fmt u_fmt (
        .data_i  (data_i),
        .valid_i (data_valid_i),
        .width_i (width_e'(width_sel_i)),
        .slots_o (fmt_w)
    );

    // Frame assembly: tag and command slots on top, slot 3 first below them.
    always_comb begin
        frame_w[FRAME_W-1 -: TAG_W]                   = tag_w;
        frame_w[FRAME_W-TAG_W-1 -: SLOT_W]            = slot1_w;
        frame_w[FRAME_W-TAG_W-SLOT_W-1 -: SLOT_W]     = slot2_w;
        for (int i = 0; i < DATA_SLOTS; i++) begin
            frame_w[DATA_BASE-1-i*SLOT_W -: SLOT_W] = fmt_w[i*SLOT_W +: SLOT_W];
        end
    end

    acl_frame_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_w),
        .sync_o  (sync_o),
        .sdata_o (sdata_o)
    );
endmodule

// File: rtl/acl_frame_tx_chk.sv
// Protocol checker for acl_frame_tx: frame period, tag-phase length and
// tag-word consistency. Counts its own cycles; bound to the top below.
module acl_frame_tx_chk
    import acl_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sync_o,
    input logic [TAG_W-1:0] tag
);
    localparam int RUN_W = CNT_W + 2;

    logic             sync_q;
    logic             seen_rise;
    logic [RUN_W-1:0] since_rise;
    logic [RUN_W-1:0] high_run;
    logic             rise;
    logic             fall;

    assign rise = sync_o & ~sync_q;
    assign fall = ~sync_o & sync_q;

    // Track sync history, cycles since last rise and length of the high run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
            high_run   <= '0;
        end else begin
            sync_q <= sync_o;
            if (rise) begin
                seen_rise  <= 1'b1;
                since_rise <= RUN_W'(1);
            end else if (since_rise != '1) begin
                since_rise <= since_rise + RUN_W'(1);
            end
            high_run <= sync_o ? high_run + RUN_W'(1) : '0;
        end
    end

    // R1
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_rise) |-> (since_rise == RUN_W'(FRAME_W)));

    // R2
    tag_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (high_run == RUN_W'(TAG_W)));

    // R7
    secondary_hides_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag[ID_W-1:0] != '0) |-> (tag[TAG_W-2:TAG_W-3] == 2'b00));

    // R6
    write_implies_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag[TAG_W-3] |-> tag[TAG_W-2]);

    // R3
    slot_flag_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tag[TAG_W-2:3]) |-> tag[TAG_W-1]);
endmodule

bind acl_frame_tx acl_frame_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_o (sync_o),
    .tag    (tag_w)
);

// File: tb/tb_acl_frame_tx.sv
// Directed bench for acl_frame_tx: one task per scenario, frame captured
// bit by bit at falling edges and compared with a frame built here.
module tb_acl_frame_tx;
    import acl_tx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FW = FRAME_W;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         cmd_valid_i = 1'b0;
    logic                         cmd_read_i = 1'b0;
    logic [IDX_W-1:0]             cmd_index_i = '0;
    logic [REGD_W-1:0]            cmd_wdata_i = '0;
    logic [ID_W-1:0]              codec_id_i = '0;
    logic [1:0]                   width_sel_i = 2'b10;
    logic [DATA_SLOTS-1:0]        data_valid_i = '0;
    logic [DATA_SLOTS*SLOT_W-1:0] data_i = '0;
    logic                         sync_o;
    logic                         sdata_o;

    int n_checks = 0;
    int n_fail = 0;
    logic last_sync = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acl_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i),
        .cmd_read_i(cmd_read_i), .cmd_index_i(cmd_index_i),
        .cmd_wdata_i(cmd_wdata_i), .codec_id_i(codec_id_i),
        .width_sel_i(width_sel_i), .data_valid_i(data_valid_i),
        .data_i(data_i), .sync_o(sync_o), .sdata_o(sdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected frame from the current inputs, per the requirements.
    function automatic logic [FW-1:0] model_frame();
        logic [FW-1:0] f;
        logic [15:0] t;
        logic [19:0] s1, s2, m, w;
        t = 16'h0;
        t[15] = cmd_valid_i || (data_valid_i != 0);
        if (cmd_valid_i && codec_id_i == 2'b00) begin
            t[14] = 1'b1;
            t[13] = !cmd_read_i;
        end
        for (int k = 0; k < 10; k++) t[12-k] = data_valid_i[k];
        if (cmd_valid_i) t[1:0] = codec_id_i;
        s1 = cmd_valid_i ? {cmd_read_i, cmd_index_i, 12'h000} : 20'h0;
        s2 = (cmd_valid_i && !cmd_read_i) ? {cmd_wdata_i, 4'h0} : 20'h0;
        case (width_sel_i)
            2'b00:   m = 20'hFFFF0;
            2'b01:   m = 20'hFFFFC;
            default: m = 20'hFFFFF;
        endcase
        f = '0;
        f[FW-1 -: 16] = t;
        f[FW-17 -: 20] = s1;
        f[FW-37 -: 20] = s2;
        for (int k = 0; k < 10; k++) begin
            w = data_valid_i[k] ? (data_i[k*20 +: 20] & m) : 20'h0;
            f[FW-57-k*20 -: 20] = w;
        end
        return f;
    endfunction

    function automatic logic [19:0] slot_of(input logic [FW-1:0] f, input int n);
        return f[FW-17-(n-1)*20 -: 20];
    endfunction

    function automatic logic [15:0] tag_of(input logic [FW-1:0] f);
        return f[FW-1 -: 16];
    endfunction

    // Wait for a sync rise, then capture one frame; optionally change inputs mid-frame.
    task automatic grab(output logic [FW-1:0] f, output int waited, output bit sync_ok,
                        input int disturb_at);
        waited = 0;
        sync_ok = 1'b1;
        forever begin
            @(negedge clk);
            waited++;
            if (sync_o === 1'b1 && last_sync === 1'b0) break;
            last_sync = sync_o;
            if (waited > 2000) break;
        end
        last_sync = sync_o;
        f = '0;
        f[FW-1] = sdata_o;
        for (int k = 1; k < FW; k++) begin
            @(negedge clk);
            f[FW-1-k] = sdata_o;
            if (sync_o !== (k < 16)) sync_ok = 1'b0;
            last_sync = sync_o;
            if (k == disturb_at) begin
                cmd_valid_i  = 1'b1;
                cmd_read_i   = 1'b1;
                cmd_index_i  = 7'h55;
                codec_id_i   = 2'b00;
                data_valid_i = 10'h3FF;
                data_i       = ~data_i;
            end
        end
    endtask

    task automatic set_cmd(input bit v, input bit rd, input logic [6:0] idx,
                           input logic [15:0] wd, input logic [1:0] id);
        cmd_valid_i = v; cmd_read_i = rd; cmd_index_i = idx;
        cmd_wdata_i = wd; codec_id_i = id;
    endtask

    task automatic t_reset();
        logic [FW-1:0] f;
        int w;
        bit s;
        rst_n = 1'b0;
        set_cmd(1'b0, 1'b0, 7'h0, 16'h0, 2'b00);
        data_valid_i = '0;
        repeat (6) @(negedge clk);
        // R12: outputs low under reset
        chk(sync_o === 1'b0 && sdata_o === 1'b0, "R12", "outputs in reset",
            FW'({sync_o, sdata_o}), '0);
        rst_n = 1'b1;
        grab(f, w, s, -1);
        // R12: first frame starts at first edge after release
        chk(w == 1, "R12", "first frame start delay", FW'(w), FW'(1));
        // R2: sync high for tag phase only
        chk(s, "R2", "sync shape", FW'(s), FW'(1));
        // R8: idle frame is all zeros, frame-valid clear (R3)
        chk(f == '0, "R8", "idle frame", f, '0);
    endtask

    task automatic t_prim_read();
        logic [FW-1:0] f;
        int w;
        bit s;
        set_cmd(1'b1, 1'b1, 7'h26, 16'hDEAD, 2'b00);
        data_valid_i = '0;
        grab(f, w, s, -1);
        // R5: tag, slot 1 encoding, empty slot 2
        chk(tag_of(f) == 16'hC000, "R5", "read tag", FW'(tag_of(f)), FW'(16'hC000));
        chk(slot_of(f, 1) == 20'hA6000, "R5", "read slot1", FW'(slot_of(f, 1)), FW'(20'hA6000));
        chk(slot_of(f, 2) == 20'h0, "R8", "read slot2 zero", FW'(slot_of(f, 2)), '0);
        // R1: back-to-back frame
        chk(w == 1, "R1", "frame spacing", FW'(w), FW'(1));
    endtask

    task automatic t_prim_write();
        logic [FW-1:0] f;
        int w;
        bit s;
        set_cmd(1'b1, 1'b0, 7'h02, 16'h8808, 2'b00);
        grab(f, w, s, -1);
        // R6: tag, slot 1 and slot 2 for a primary write
        chk(tag_of(f) == 16'hE000, "R6", "write tag", FW'(tag_of(f)), FW'(16'hE000));
        chk(slot_of(f, 1) == 20'h02000, "R6", "write slot1", FW'(slot_of(f, 1)), FW'(20'h02000));
        chk(slot_of(f, 2) == 20'h88080, "R6", "write slot2", FW'(slot_of(f, 2)), FW'(20'h88080));
    endtask

    task automatic t_secondary();
        logic [FW-1:0] f;
        int w;
        bit s;
        set_cmd(1'b1, 1'b0, 7'h2C, 16'hBB80, 2'b10);
        grab(f, w, s, -1);
        // R7: secondary write keeps command slots, hides their flags
        chk(tag_of(f) == 16'h8002, "R7", "secondary write tag", FW'(tag_of(f)), FW'(16'h8002));
        chk(slot_of(f, 2) == 20'hBB800, "R7", "secondary slot2", FW'(slot_of(f, 2)), FW'(20'hBB800));
        set_cmd(1'b1, 1'b1, 7'h7C, 16'h1234, 2'b11);
        grab(f, w, s, -1);
        chk(tag_of(f) == 16'h8003, "R7", "secondary read tag", FW'(tag_of(f)), FW'(16'h8003));
        chk(slot_of(f, 1) == 20'hFC000, "R7", "secondary read slot1", FW'(slot_of(f, 1)), FW'(20'hFC000));
    endtask

    task automatic t_data_slots();
        logic [FW-1:0] f, e;
        int w;
        bit s;
        set_cmd(1'b0, 1'b0, 7'h0, 16'h0, 2'b00);
        width_sel_i = 2'b10;
        for (int k = 0; k < 10; k++) data_i[k*20 +: 20] = 20'h12345 + 20'(k) * 20'h11111;
        data_valid_i = 10'b1011001101;
        e = model_frame();
        grab(f, w, s, -1);
        // R4: slot flags in tag bits 12..3
        chk(tag_of(f) == 16'h9668, "R4", "data tag", FW'(tag_of(f)), FW'(16'h9668));
        // R8: slot 4 invalid although its data is nonzero
        chk(slot_of(f, 4) == 20'h0, "R8", "invalid slot4", FW'(slot_of(f, 4)), '0);
        // R10: full frame order, MSB first
        chk(f == e, "R10", "full data frame", f, e);
        // R3: frame valid from data alone
        chk(f[FW-1] == 1'b1, "R3", "frame valid from data", FW'(f[FW-1]), FW'(1));
    endtask

    task automatic t_width();
        logic [FW-1:0] f, e;
        int w;
        bit s;
        data_i = '1;
        data_valid_i = 10'h3FF;
        for (int m = 0; m < 4; m++) begin
            width_sel_i = 2'(m);
            e = model_frame();
            grab(f, w, s, -1);
            // R9: trailing bits zeroed per width select
            chk(f == e, "R9", $sformatf("width code %0d frame", m), f, e);
        end
        chk(slot_of(f, 12) == 20'hFFFFF, "R9", "20-bit slot12", FW'(slot_of(f, 12)), FW'(20'hFFFFF));
    endtask

    task automatic t_latch();
        logic [FW-1:0] f, e_old, e_new;
        int w;
        bit s;
        set_cmd(1'b1, 1'b0, 7'h18, 16'hA5C3, 2'b00);
        width_sel_i = 2'b01;
        for (int k = 0; k < 10; k++) data_i[k*20 +: 20] = 20'hF0F0F ^ 20'(k * 37);
        data_valid_i = 10'b0000111100;
        e_old = model_frame();
        grab(f, w, s, 120);
        e_new = model_frame();
        // R11: mid-frame change does not touch the frame in flight
        chk(f == e_old, "R11", "frame under mid change", f, e_old);
        grab(f, w, s, -1);
        chk(f == e_new, "R11", "next frame picks up change", f, e_new);
        // R1: still back-to-back
        chk(w == 1, "R1", "frame spacing after change", FW'(w), FW'(1));
        chk(s, "R2", "sync shape later frame", FW'(s), FW'(1));
    endtask

    initial begin
        t_reset();
        t_prim_read();
        t_prim_write();
        t_secondary();
        t_data_slots();
        t_width();
        t_latch();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule